// File: doc/BRIEF.md
# Calendar Shadow Register Synchronizer

This block sits between a calendar that counts in a slow real-time clock domain and a peripheral bus that runs on a much faster bus clock. The calendar presents three live words: subseconds, time of day and date. On every real-time clock edge the block takes one snapshot of all three words and flips a toggle bit. The toggle is carried into the bus domain through a flop chain. When the synchronized toggle changes, the three shadow words load together from the snapshot and a sync status flag is set. Bus reads then return stable shadow values and never stall.

While a low-power indicator is high, no snapshot is taken, so the shadows and the flag stay as they are. The first real-time clock edge after the indicator falls takes a snapshot again. Software clears the sync flag by writing 0 to it and can then poll for the next refresh. A bypass input makes the read outputs return the live calendar words directly, which removes the synchronization delay.

The bus clock is assumed to be at least four times faster than the real-time clock. This leaves room for the toggle to cross, and for the shadows to load, before the next snapshot replaces the current one.

Top module: `cal_shadow_sync`

## Requirements
- R1: While reset is high and just after it, the shadow read outputs are all zero and the sync flag reads 0.
- R2: At each real-time clock rising edge where low-power and reset are low, the live subsecond, time and date words are captured. With bypass at 0 they appear on the read outputs no later than SYNC_STAGES+2 bus clock cycles after that edge.
- R3: Every shadow load sets the sync flag to 1 in the same bus clock cycle in which the shadow outputs change.
- R4: At a real-time clock edge where low-power is 1, no capture takes place. The shadow outputs and the sync flag keep their values, whatever the live words do.
- R5: After low-power returns to 0, the next real-time clock edge captures the live words, so the shadows are current within one real-time clock period of the exit.
- R6: With bypass at 1, the three read outputs equal the three live input words. With bypass at 0, they show the shadow words.
- R7: A flag write (write-enable 1) with data bit 0 clears the sync flag on the next bus clock edge. A flag write with data bit 1 leaves the flag unchanged.
- R8: When a clearing write falls in the same bus clock cycle as a shadow load, the sync flag ends up 1.
- R9: All three shadow words load in the same bus clock cycle from one snapshot and hold their values between loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rtc_clk | input | 1 | Real-time clock, the domain of the calendar words |
| pclk | input | 1 | Bus clock, the domain of the shadows and the flag |
| rst | input | 1 | Active-high synchronous reset, held across edges of both clocks |
| live_sub | input | SUB_W | Live subsecond count (rtc_clk domain) |
| live_tod | input | TOD_W | Live time-of-day word (rtc_clk domain) |
| live_date | input | DATE_W | Live date word (rtc_clk domain) |
| lowpwr | input | 1 | Low-power indicator; 1 blocks captures (rtc_clk domain) |
| bypass | input | 1 | 1 makes reads return the live words |
| flag_we | input | 1 | Write strobe to the sync flag (pclk domain) |
| flag_wd | input | 1 | Write data bit for the sync flag; 0 clears it |
| rd_sub | output | SUB_W | Subsecond read data |
| rd_tod | output | TOD_W | Time-of-day read data |
| rd_date | output | DATE_W | Date read data |
| sync_flag | output | 1 | Set by each shadow load, cleared by software |

## Verification
The bench builds the block with the default word widths and SYNC_STAGES set to 3. With a 125 MHz bus clock and a real-time clock ten times slower, the deeper chain still finishes a load well before the next snapshot, so the full crossing latency is exercised. The slow real-time clock leaves quiet bus cycles between loads. In those cycles, clear and set writes to the flag can be tested on their own, and a clearing write held across a load shows which of the two wins. The low-power windows, with bypass toggled inside them, show that the frozen shadows, the live words and the resumed capture each reach the read outputs.

// File: rtl/cal_shadow_pkg.sv
package cal_shadow_pkg;

    localparam int SUB_W  = 16;
    localparam int TOD_W  = 24;
    localparam int DATE_W = 24;
    localparam int SNAP_W = SUB_W + TOD_W + DATE_W;

    typedef struct packed {
        logic [SUB_W-1:0]  sub;
        logic [TOD_W-1:0]  tod;
        logic [DATE_W-1:0] date;
    } cal_snap_t;

    typedef enum logic [1:0] {
        FLAG_HOLD  = 2'd0,
        FLAG_SET   = 2'd1,
        FLAG_CLEAR = 2'd2
    } flag_act_t;

    function automatic cal_snap_t snap_make(
        input logic [SUB_W-1:0]  sub,
        input logic [TOD_W-1:0]  tod,
        input logic [DATE_W-1:0] date
    );
        cal_snap_t s;
        s.sub  = sub;
        s.tod  = tod;
        s.date = date;
        return s;
    endfunction

    // A load always wins over a software clear in the same cycle.
    function automatic flag_act_t flag_decide(
        input logic load,
        input logic we,
        input logic wd
    );
        if (load)
            return FLAG_SET;
        else if (we && !wd)
            return FLAG_CLEAR;
        else
            return FLAG_HOLD;
    endfunction

endpackage

// File: rtl/cal_rtc_capture.sv
module cal_rtc_capture
    import cal_shadow_pkg::*;
(
    input  logic      rtc_clk,
    input  logic      rst,
    input  cal_snap_t live,
    input  logic      lowpwr,
    output cal_snap_t snap,
    output logic      tgl
);

    logic capture;

    always_comb capture = !lowpwr;

    always_ff @(posedge rtc_clk) begin
        if (rst) begin
            snap <= '0;
            tgl  <= 1'b0;
        end else if (capture) begin
            snap <= live;
            tgl  <= ~tgl;
        end
    end

endmodule

// File: rtl/cal_toggle_sync.sv
module cal_toggle_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic pulse
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              edge_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) edge_q <= 1'b0;
        else     edge_q <= chain[LAST];
    end

    always_comb pulse = chain[LAST] ^ edge_q;

endmodule

// File: rtl/cal_shadow_bank.sv
module cal_shadow_bank
    import cal_shadow_pkg::*;
(
    input  logic      pclk,
    input  logic      rst,
    input  logic      load,
    input  cal_snap_t snap,
    input  logic      flag_we,
    input  logic      flag_wd,
    output cal_snap_t shadow,
    output logic      flag
);

    flag_act_t act;

    always_comb act = flag_decide(load, flag_we, flag_wd);

    always_ff @(posedge pclk) begin
        if (rst)       shadow <= '0;
        else if (load) shadow <= snap;
    end

    always_ff @(posedge pclk) begin
        if (rst) begin
            flag <= 1'b0;
        end else begin
            case (act)
                FLAG_SET:   flag <= 1'b1;
                FLAG_CLEAR: flag <= 1'b0;
                default:    flag <= flag;
            endcase
        end
    end

endmodule

// File: rtl/cal_shadow_sync.sv
module cal_shadow_sync
    import cal_shadow_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              rtc_clk,
    input  logic              pclk,
    input  logic              rst,
    input  logic [SUB_W-1:0]  live_sub,
    input  logic [TOD_W-1:0]  live_tod,
    input  logic [DATE_W-1:0] live_date,
    input  logic              lowpwr,
    input  logic              bypass,
    input  logic              flag_we,
    input  logic              flag_wd,
    output logic [SUB_W-1:0]  rd_sub,
    output logic [TOD_W-1:0]  rd_tod,
    output logic [DATE_W-1:0] rd_date,
    output logic              sync_flag
);

    cal_snap_t live_w;
    cal_snap_t snap_q;
    cal_snap_t shadow_q;
    cal_snap_t rd_w;
    logic      tgl_q;
    logic      load_p;

    always_comb live_w = snap_make(live_sub, live_tod, live_date);

    cal_rtc_capture u_cap (
        .rtc_clk (rtc_clk),
        .rst     (rst),
        .live    (live_w),
        .lowpwr  (lowpwr),
        .snap    (snap_q),
        .tgl     (tgl_q)
    );

    cal_toggle_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (pclk),
        .rst   (rst),
        .din   (tgl_q),
        .pulse (load_p)
    );

    cal_shadow_bank u_bank (
        .pclk    (pclk),
        .rst     (rst),
        .load    (load_p),
        .snap    (snap_q),
        .flag_we (flag_we),
        .flag_wd (flag_wd),
        .shadow  (shadow_q),
        .flag    (sync_flag)
    );

    always_comb rd_w = bypass ? live_w : shadow_q;

    assign rd_sub  = rd_w.sub;
    assign rd_tod  = rd_w.tod;
    assign rd_date = rd_w.date;

endmodule

// File: rtl/cal_shadow_chk.sv
module cal_shadow_chk
    import cal_shadow_pkg::*;
(
    input logic      rtc_clk,
    input logic      pclk,
    input logic      rst,
    input logic      lowpwr,
    input logic      tgl,
    input logic      load,
    input cal_snap_t shadow,
    input logic      flag,
    input logic      flag_we,
    input logic      flag_wd
);

    // R3
    a_r3_load_sets_flag: assert property (@(posedge pclk) disable iff (rst)
        load |=> flag);

    // R8
    a_r8_load_beats_clear: assert property (@(posedge pclk) disable iff (rst)
        (load && flag_we && !flag_wd) |=> flag);

    // R7
    a_r7_clear_works: assert property (@(posedge pclk) disable iff (rst)
        (!load && flag_we && !flag_wd) |=> !flag);

    // R7
    a_r7_no_spurious_set: assert property (@(posedge pclk) disable iff (rst)
        (!load && !flag) |=> !flag);

    // R9
    a_r9_shadow_hold: assert property (@(posedge pclk) disable iff (rst)
        !load |=> $stable(shadow));

    // R4
    a_r4_lowpwr_freeze: assert property (@(posedge rtc_clk) disable iff (rst)
        lowpwr |=> $stable(tgl));

    // R2
    a_r2_capture_toggles: assert property (@(posedge rtc_clk) disable iff (rst)
        !lowpwr |=> (tgl != $past(tgl)));

endmodule

bind cal_shadow_sync cal_shadow_chk u_chk (
    .rtc_clk (rtc_clk),
    .pclk    (pclk),
    .rst     (rst),
    .lowpwr  (lowpwr),
    .tgl     (tgl_q),
    .load    (load_p),
    .shadow  (shadow_q),
    .flag    (sync_flag),
    .flag_we (flag_we),
    .flag_wd (flag_wd)
);

// File: tb/sim_cal_shadow_sync.sv
module sim_cal_shadow_sync;
    import cal_shadow_pkg::*;

    logic              rtc_clk = 1'b0;
    logic              pclk    = 1'b0;
    logic              rst     = 1'b1;
    logic [SUB_W-1:0]  live_sub  = '0;
    logic [TOD_W-1:0]  live_tod  = '0;
    logic [DATE_W-1:0] live_date = '0;
    logic              lowpwr  = 1'b0;
    logic              bypass  = 1'b0;
    logic              flag_we = 1'b0;
    logic              flag_wd = 1'b0;
    logic [SUB_W-1:0]  rd_sub;
    logic [TOD_W-1:0]  rd_tod;
    logic [DATE_W-1:0] rd_date;
    logic              sync_flag;

    int checks = 0;
    int errors = 0;
    int step_n = 0;
    bit clr_held = 1'b0;

    cal_snap_t exp_q[$];
    cal_snap_t last_pushed = '0;
    cal_snap_t mon_last = '0;
    cal_snap_t frozen;

    always #4 pclk = ~pclk;
    initial begin
        #3;
        forever #40 rtc_clk = ~rtc_clk;
    end

    cal_shadow_sync #(.SYNC_STAGES(3)) u0 (
        .rtc_clk   (rtc_clk),
        .pclk      (pclk),
        .rst       (rst),
        .live_sub  (live_sub),
        .live_tod  (live_tod),
        .live_date (live_date),
        .lowpwr    (lowpwr),
        .bypass    (bypass),
        .flag_we   (flag_we),
        .flag_wd   (flag_wd),
        .rd_sub    (rd_sub),
        .rd_tod    (rd_tod),
        .rd_date   (rd_date),
        .sync_flag (sync_flag)
    );

    function automatic cal_snap_t rd_now();
        return snap_make(rd_sub, rd_tod, rd_date);
    endfunction

    function automatic cal_snap_t live_now();
        return snap_make(live_sub, live_tod, live_date);
    endfunction

    task automatic check_snap(input string req, input cal_snap_t act, input cal_snap_t exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic step_live();
        step_n++;
        live_sub  = SUB_W'(step_n * 3 + 1);
        live_tod  = TOD_W'(step_n * 7 + 2);
        live_date = DATE_W'(step_n * 11 + 5);
    endtask

    task automatic run_periods(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge rtc_clk);
            step_live();
        end
    endtask

    // Driver: expected shadow loads come from the live words at each capturing edge.
    always @(posedge rtc_clk) begin
        if (!rst && !lowpwr) begin
            if (live_now() != last_pushed) begin
                exp_q.push_back(live_now());
                last_pushed = live_now();
            end
        end
    end

    // Monitor: every visible change of the shadow outputs pops one expected item.
    always @(negedge pclk) begin
        if (!rst && !bypass && rd_now() != mon_last) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R2: unexpected shadow change to %h, expected none", rd_now());
            end else begin
                check_snap("R2/R9 shadow snapshot", rd_now(), exp_q.pop_front());
            end
            check_bit(clr_held ? "R8 load beats clear" : "R3 flag set on load", sync_flag, 1'b1);
            mon_last = rd_now();
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #60000;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (20) @(negedge pclk);
        check_snap("R1 reset shadows", rd_now(), '0);
        check_bit("R1 reset flag", sync_flag, 1'b0);
        rst = 1'b0;
        @(negedge pclk);
        check_snap("R1 shadows after reset", rd_now(), '0);
        check_bit("R1 flag after reset", sync_flag, 1'b0);

        // R2/R3/R9: normal running, scoreboard compares each load
        run_periods(6);

        // R2: latency bound, sampled SYNC_STAGES+2 cycles after the capturing edge
        @(posedge rtc_clk);
        frozen = live_now();
        repeat (5) @(negedge pclk);
        check_snap("R2 latency bound", rd_now(), frozen);
        check_bit("R3 flag after load", sync_flag, 1'b1);

        // R8: clearing write held across loads
        @(negedge pclk);
        clr_held = 1'b1;
        flag_we = 1'b1;
        flag_wd = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge rtc_clk);
            step_live();
            @(posedge rtc_clk);
            repeat (8) @(negedge pclk);
            check_bit("R7 held clear after load", sync_flag, 1'b0);
        end
        flag_we = 1'b0;
        clr_held = 1'b0;

        // R4: low-power window
        @(negedge rtc_clk);
        lowpwr = 1'b1;
        repeat (10) @(negedge pclk);
        frozen = rd_now();
        flag_we = 1'b1; flag_wd = 1'b1;
        @(negedge pclk);
        flag_we = 1'b0;
        check_bit("R7 write 1 keeps flag", sync_flag, 1'b1);
        flag_we = 1'b1; flag_wd = 1'b0;
        @(negedge pclk);
        flag_we = 1'b0;
        check_bit("R7 write 0 clears flag", sync_flag, 1'b0);
        flag_we = 1'b1; flag_wd = 1'b1;
        @(negedge pclk);
        flag_we = 1'b0;
        check_bit("R7 write 1 does not set flag", sync_flag, 1'b0);
        for (int i = 0; i < 3; i++) begin
            @(negedge rtc_clk);
            step_live();
            @(posedge rtc_clk);
            repeat (8) @(negedge pclk);
            check_snap("R4 shadows frozen", rd_now(), frozen);
            check_bit("R4 flag unchanged", sync_flag, 1'b0);
        end

        // R6: bypass inside the frozen window
        bypass = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step_live();
            #1;
            check_snap("R6 bypass returns live", rd_now(), live_now());
        end
        @(negedge pclk);
        bypass = 1'b0;
        #1;
        check_snap("R6 bypass off returns shadow", rd_now(), frozen);

        // R5: resume after low-power exit
        @(negedge rtc_clk);
        lowpwr = 1'b0;
        step_live();
        frozen = live_now();
        @(posedge rtc_clk);
        repeat (6) @(negedge pclk);
        check_snap("R5 resume capture", rd_now(), frozen);
        check_bit("R5 flag after resume", sync_flag, 1'b1);

        // More traffic, then drain
        run_periods(4);
        @(posedge rtc_clk);
        repeat (8) @(negedge pclk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R2: %0d loads pending, expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule